// File: doc/BRIEF.md
# Two-Phase ROM Word Sequencer

The block steps through a small read-only table one word per phase period and holds each word on a registered output. An internal divider derives a slow phase signal `phase_q` and its complement `phase_nq` from the system clock. Each phase edge is a one-cycle internal event in the system clock domain. The rising edge of `phase_q` advances an address counter and, in the same clock, loads the data register from the table. The rising edge of `phase_nq` copies the counter into an address register, and that register drives the table. The table lookup therefore settles during the low half of `phase_q`, and the result is captured at the next rising edge.

A single `enable` input gates the divider and the table read. While it is low, nothing moves: the phases, the divider position, the counter, the address register and the output word all keep their values. When `enable` returns high, sequencing resumes from the point where it stopped. The table contents come from a packed parameter, and the data width and the address width are set separately.

Top module: `rom_phase_sequencer`

## Requirements
- R1: While `rst_n` is low, `data_out` is 0, `phase_q` is 0 and `phase_nq` is 1. The first word presented after reset is the word at address 0.
- R2: `phase_nq` is the bitwise complement of `phase_q` in every cycle.
- R3: With `enable` high, `phase_q` toggles once every DIV/2 enabled clock cycles, so one full phase period lasts DIV enabled cycles.
- R4: A cycle in which `enable` is low does not advance the divider. The phases hold, and the count of enabled cycles resumes where it stopped.
- R5: At the clock edge where `phase_q` goes from 0 to 1, `data_out` takes the table word at the address register. The k-th rising edge of `phase_q` after reset presents the word at address (k-1) mod 2^ADDR_W.
- R6: The address counter increments on each rising edge of `phase_q` and wraps to 0 after address 2^ADDR_W-1. The output therefore shows the last word and then the word at address 0.
- R7: The address register loads the counter at each falling edge of `phase_q`, which is the rising edge of `phase_nq`. The word captured at a rising edge of `phase_q` is therefore the one addressed during the preceding low half.
- R8: `data_out` keeps its value in every cycle in which `enable` is low.
- R9: Table word i is `ROM_INIT[i*DATA_W +: DATA_W]`, with word 0 in the least significant bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Runs the phase divider and the table read |
| data_out | output | DATA_W | Registered table word |
| phase_q | output | 1 | True phase of the derived clock |
| phase_nq | output | 1 | Complement phase of the derived clock |

## Verification
Two updates land in the same system clock: the counter increment and the data capture, both on the `phase_q` rising event. The capture must use the address register and not the counter it shares a clock with. The bench drives `enable` mostly high, so that many rising events occur, including the wrap from the last address to the first. It also inserts random low cycles, some of them exactly on a divider boundary. Each observed word is judged against a reference that counts phase rising edges and indexes a table formula of the bench's own. Any race between increment and capture would show up there as a word that is off by one.

// File: rtl/seq_pkg.sv
package seq_pkg;
  // cycles per half phase period; DIV below 2 is treated as 2
  function automatic int half_len(input int div);
    return (div < 2) ? 1 : div / 2;
  endfunction

  // width of a counter that must hold 0..n-1
  function automatic int cnt_width(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

  // entry count of a table addressed by aw bits
  function automatic int table_depth(input int aw);
    return 1 << aw;
  endfunction
endpackage

// File: rtl/phase_gen.sv
module phase_gen #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  output logic phase_q,
  output logic q_rise_evt,
  output logic nq_rise_evt
);
  localparam int HALF = seq_pkg::half_len(DIV);
  localparam int CW   = seq_pkg::cnt_width(HALF);

  logic [CW-1:0] div_cnt;
  logic          at_last;
  logic          step;

  assign at_last     = (div_cnt == CW'(HALF - 1));
  assign step        = enable && at_last;
  assign q_rise_evt  = step && !phase_q;
  assign nq_rise_evt = step && phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_cnt <= '0;
      phase_q <= 1'b0;
    end else if (enable) begin
      if (at_last) begin
        div_cnt <= '0;
        phase_q <= !phase_q;
      end else begin
        div_cnt <= div_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/addr_stage.sv
module addr_stage #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              q_rise_evt,
  input  logic              nq_rise_evt,
  output logic [ADDR_W-1:0] cnt_val,
  output logic [ADDR_W-1:0] addr_val
);
  // counter advances on the true-phase event and wraps naturally
  always_ff @(posedge clk) begin
    if (!rst_n)          cnt_val <= '0;
    else if (q_rise_evt) cnt_val <= cnt_val + 1'b1;
  end

  // address register follows the counter on the complement-phase event
  always_ff @(posedge clk) begin
    if (!rst_n)           addr_val <= '0;
    else if (nq_rise_evt) addr_val <= cnt_val;
  end
endmodule

// File: rtl/rom_lookup.sv
module rom_lookup #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4,
  parameter int DEPTH  = 16,
  parameter logic [DEPTH*DATA_W-1:0] ROM_INIT = '0
) (
  input  logic              enable,
  input  logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] word
);
  logic [DATA_W-1:0] table_w [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    assign table_w[i] = ROM_INIT[i*DATA_W +: DATA_W];
  end

  assign word = enable ? table_w[addr] : '0;
endmodule

// File: rtl/data_stage.sv
module data_stage #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [DATA_W-1:0] word_in,
  output logic [DATA_W-1:0] data_out
);
  always_ff @(posedge clk) begin
    if (!rst_n)       data_out <= '0;
    else if (capture) data_out <= word_in;
  end
endmodule

// File: rtl/rom_phase_sequencer.sv
module rom_phase_sequencer #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4,
  parameter int DIV    = 4,
  parameter logic [(1<<ADDR_W)*DATA_W-1:0] ROM_INIT = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  output logic [DATA_W-1:0] data_out,
  output logic              phase_q,
  output logic              phase_nq
);
  localparam int DEPTH = seq_pkg::table_depth(ADDR_W);

  // named internal events, visible to the bound checker
  logic              q_rise_evt;
  logic              nq_rise_evt;
  logic [ADDR_W-1:0] cnt_val;
  logic [ADDR_W-1:0] addr_val;
  logic [DATA_W-1:0] rom_word;

  phase_gen #(.DIV(DIV)) u_phase (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .phase_q(phase_q), .q_rise_evt(q_rise_evt), .nq_rise_evt(nq_rise_evt)
  );

  addr_stage #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst_n(rst_n),
    .q_rise_evt(q_rise_evt), .nq_rise_evt(nq_rise_evt),
    .cnt_val(cnt_val), .addr_val(addr_val)
  );

  rom_lookup #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DEPTH(DEPTH), .ROM_INIT(ROM_INIT)) u_rom (
    .enable(enable), .addr(addr_val), .word(rom_word)
  );

  data_stage #(.DATA_W(DATA_W)) u_data (
    .clk(clk), .rst_n(rst_n), .capture(q_rise_evt),
    .word_in(rom_word), .data_out(data_out)
  );

  assign phase_nq = !phase_q;
endmodule

// File: rtl/seq_checker.sv
module seq_checker #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic              phase_q,
  input logic              phase_nq,
  input logic [DATA_W-1:0] data_out,
  input logic              q_rise_evt,
  input logic              nq_rise_evt,
  input logic [ADDR_W-1:0] cnt_val,
  input logic [ADDR_W-1:0] addr_val,
  input logic [DATA_W-1:0] rom_word
);
  // R2
  phase_compl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase_nq == !phase_q);

  // R4
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> $stable(phase_q));

  // R3
  q_rise_sets_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_rise_evt |=> phase_q);

  // R3
  nq_rise_clears_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nq_rise_evt |=> !phase_q);

  // R7
  events_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(q_rise_evt && nq_rise_evt));

  // R6
  counter_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_rise_evt |=> cnt_val == ADDR_W'($past(cnt_val) + 1'b1));

  // R7
  addr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nq_rise_evt |=> addr_val == $past(cnt_val));

  // R5
  data_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_rise_evt |=> data_out == $past(rom_word));

  // R8
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> $stable(data_out) && $stable(addr_val) && $stable(cnt_val));
endmodule

bind rom_phase_sequencer seq_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .phase_q(phase_q), .phase_nq(phase_nq),
  .data_out(data_out), .q_rise_evt(q_rise_evt), .nq_rise_evt(nq_rise_evt),
  .cnt_val(cnt_val), .addr_val(addr_val), .rom_word(rom_word)
);

// File: tb/rom_phase_sequencer_test.sv
`timescale 1ns/1ps
module rom_phase_sequencer_test;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;
  localparam int DIV    = 4;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int HALF   = DIV / 2;

  // R9: word i is stored at ROM_INIT[i*DATA_W +: DATA_W]
  function automatic logic [DATA_W-1:0] word_of(input int i);
    return DATA_W'(i * 37 + 5);
  endfunction

  function automatic logic [DEPTH*DATA_W-1:0] build_image();
    logic [DEPTH*DATA_W-1:0] img = '0;
    for (int i = 0; i < DEPTH; i++) img[i*DATA_W +: DATA_W] = word_of(i);
    return img;
  endfunction

  localparam logic [DEPTH*DATA_W-1:0] IMAGE = build_image();

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic [DATA_W-1:0] data_out;
  logic phase_q, phase_nq;

  always #2 clk = !clk;

  rom_phase_sequencer #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DIV(DIV), .ROM_INIT(IMAGE)) uut (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .data_out(data_out), .phase_q(phase_q), .phase_nq(phase_nq)
  );

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // reference: count enabled cycles and true-phase rising edges
  int m_hc = 0;
  bit m_q = 1'b0;
  int m_rises = 0;
  bit m_prev_en = 1'b0;

  always @(posedge clk) begin
    m_prev_en <= enable;
    if (!rst_n) begin
      m_hc <= 0; m_q <= 1'b0; m_rises <= 0;
    end else if (enable) begin
      if (m_hc == HALF - 1) begin
        m_hc <= 0;
        m_q  <= !m_q;
        if (!m_q) m_rises <= m_rises + 1;
      end else begin
        m_hc <= m_hc + 1;
      end
    end
  end

  function automatic logic [DATA_W-1:0] exp_data(input int rises);
    return (rises == 0) ? '0 : word_of((rises - 1) % DEPTH);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare all outputs against the reference, tagging by situation
  task automatic compare_all();
    string ptag, dtag;
    check("R2 complement phase", 32'(phase_nq), 32'(!phase_q));
    ptag = m_prev_en ? "R3 phase toggle" : "R4 phase hold";
    check(ptag, 32'(phase_q), 32'(m_q));
    if (!m_prev_en)                             dtag = "R8 data hold";
    else if (m_rises > DEPTH && (m_rises - 1) % DEPTH == 0) dtag = "R6 wrap to word 0";
    else if (m_rises >= 2)                      dtag = "R7 latched address word";
    else                                        dtag = "R5 word capture";
    check(dtag, 32'(data_out), 32'(exp_data(m_rises)));
  endtask

  task automatic run(input int n, input int low_pct);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare_all();
      enable = (($urandom % 100) >= low_pct);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset data", 32'(data_out), 32'h0);
    check("R1 reset phase_q", 32'(phase_q), 32'h0);
    check("R1 reset phase_nq", 32'(phase_nq), 32'h1);
    rst_n = 1'b1;
    enable = 1'b1;
    // R5 R6: first word is address 0, run past two wraps
    run(3 * DEPTH * DIV, 0);
    // R4 R8: long idle stretch holds everything
    enable = 1'b0;
    run(20, 100);
    // corner: drop enable exactly at a divider boundary, then resume
    for (int k = 0; k < 6; k++) begin
      enable = 1'b1;
      run(HALF, 0);
      enable = 1'b0;
      run(3, 100);
    end
    // R1 again: reset in mid-run, then first word must be address 0
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R1 mid-run reset data", 32'(data_out), 32'h0);
    check("R1 mid-run reset phase", 32'(phase_q), 32'h0);
    rst_n = 1'b1;
    enable = 1'b1;
    run(DIV + 1, 0);
    // constrained random enable patterns
    run(4000, 25);
    run(4000, 60);
    run(2000, 5);
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule